// File: doc/BRIEF.md
# Programmable Down-Counting Counter/Timer

This block is a 16-bit down counter that advances once for every cycle in which its clock enable `tick_en` is high. Its start value comes from two byte-wide preset registers, one upper and one lower. A small byte-wide register port lets a processor write the presets, choose the mode, and issue start, stop and time-out commands. The same port reads back the live count. The low-byte read also captures the upper byte, so the processor always sees a matched pair of bytes.

The block has three modes. In timer mode the count reloads on every terminal count and the output toggles, so the output is a continuous square wave whose period is twice the preset. The same wave can serve as a 16x clock source for a serial receiver or transmitter. In one-shot mode a start command begins a single delay. At the end of the delay the counter stops at zero and drives its output high. In receive time-out mode the processor's start command has no effect. Each character strobe from a receiver reloads the count and restarts it, so the count only expires once incoming data has paused for the preset time. Every terminal count sets a status flag intended for an interrupt status register. Only the stop command clears that flag.

Top module: `ctmr_core`

## Requirements
- R1: A write to address 0 sets the upper preset byte and a write to address 1 sets the lower byte. A write to address 2 (start) copies the 16-bit preset into the count and starts counting, except in time-out mode.
- R2: Each cycle with `tick_en` high decrements a running count. The terminal count happens on the tick that would take the count from 1 to 0, so a preset of N gives N ticks. A preset of 0 gives 65536 ticks.
- R3: Timer mode is selected by a write to address 4 with bit 0 = 0. In this mode each terminal count reloads the preset and toggles `ct_out`, which gives a square wave with a period of 2N ticks.
- R4: One-shot mode is selected by a write to address 4 with bit 0 = 1. At the terminal count the count becomes 0, counting stops and `ct_out` goes to 1 and stays there.
- R5: `ct_flag` is set on every terminal count and stays set until a write to address 3 (stop). A stop halts counting, freezes the count, and clears both `ct_flag` and `ct_out`. Start does not clear `ct_flag`.
- R6: A write to address 5 enters time-out mode and a write to address 6 leaves it; either write halts counting and clears `ct_out`. In time-out mode a `rx_char` pulse reloads the preset and starts counting, and the start command is ignored. Outside time-out mode `rx_char` has no effect.
- R7: In time-out mode the terminal count sets the count to 0, stops counting, sets `ct_out` to 1 and raises `ct_flag` once. Further ticks leave the count at 0.
- R8: While `reg_rd` is high with address 1, `reg_rdata` shows the live low byte, and the clock edge latches the live upper byte. A read at address 0 returns the latched upper byte, even if the count has changed since the low-byte read.
- R9: After reset the count, the presets and the latched upper byte are 0. Counting is stopped, timer mode is selected, time-out mode is off, and `ct_out` and `ct_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register / command address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| rx_char | input | 1 | Receiver character-received pulse |
| ct_out | output | 1 | Square wave or terminal-count output |
| ct_flag | output | 1 | Terminal-count status flag |

## Verification
The bench targets the zero preset. A design that handled it wrong would expire on the first tick, or never, instead of after exactly 65536 ticks. It also checks the timer reload: an off-by-one error there would give a period of N+1 or N-1 ticks, and a missing toggle would leave `ct_out` flat. For time-out mode, the bench confirms that the start command is ignored and that each receiver strobe restarts the full preset. A design that got this wrong would flag a pause while data is still arriving. Finally, it reads the upper byte after the count has borrowed across the byte boundary. A design without the latch would return a torn value.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_PRE_HI  = 3'd0,
    A_PRE_LO  = 3'd1,
    A_START   = 3'd2,
    A_STOP    = 3'd3,
    A_MODE    = 3'd4,
    A_TMO_SET = 3'd5,
    A_TMO_CLR = 3'd6
  } ct_addr_e;

  typedef enum logic {
    M_TIMER   = 1'b0,
    M_ONESHOT = 1'b1
  } ct_mode_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic tmo_set;
    logic tmo_clr;
  } ct_cmd_t;
endpackage

// File: rtl/ctmr_regif.sv
module ctmr_regif
  import ctmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [BYTE_W-1:0]     reg_wdata,
  output logic [BYTE_W-1:0]     reg_rdata,
  input  logic [2*BYTE_W-1:0]   live_count,
  output logic [2*BYTE_W-1:0]   preset,
  output ct_mode_e              mode,
  output logic                  tmo_en,
  output ct_cmd_t               cmd
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] pre_hi, pre_lo, snap_hi;
  ct_addr_e          adr;
  logic              rd_lo, rd_hi;

  assign adr    = ct_addr_e'(reg_addr);
  assign preset = {pre_hi, pre_lo};
  assign rd_lo  = reg_rd && (adr == A_PRE_LO);
  assign rd_hi  = reg_rd && (adr == A_PRE_HI);

  // command strobes: one cycle, straight from the write decode
  always_comb begin
    cmd.start   = reg_wr && (adr == A_START);
    cmd.stop    = reg_wr && (adr == A_STOP);
    cmd.tmo_set = reg_wr && (adr == A_TMO_SET);
    cmd.tmo_clr = reg_wr && (adr == A_TMO_CLR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_hi  <= '0;
      pre_lo  <= '0;
      snap_hi <= '0;
      mode    <= M_TIMER;
      tmo_en  <= 1'b0;
    end else begin
      if (reg_wr && adr == A_PRE_HI) pre_hi <= reg_wdata;
      if (reg_wr && adr == A_PRE_LO) pre_lo <= reg_wdata;
      if (reg_wr && adr == A_MODE)   mode   <= ct_mode_e'(reg_wdata[0]);
      if (cmd.tmo_set)               tmo_en <= 1'b1;
      else if (cmd.tmo_clr)          tmo_en <= 1'b0;
      if (rd_lo)                     snap_hi <= live_count[CNT_W-1:BYTE_W];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (rd_lo)      reg_rdata = live_count[BYTE_W-1:0];
    else if (rd_hi) reg_rdata = snap_hi;
  end

  // R8: a low-byte read latches the upper byte that was live at that moment
  a_r8_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> snap_hi == $past(live_count[CNT_W-1:BYTE_W]));
endmodule

// File: rtl/ctmr_engine.sv
module ctmr_engine
  import ctmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             rx_char,
  input  logic [CNT_W-1:0] preset,
  input  ct_mode_e         mode,
  input  logic             tmo_en,
  input  ct_cmd_t          cmd,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             ct_out,
  output logic             ct_flag,
  output logic             term_evt
);
  // the tick that would move the count from 1 to 0 is the terminal one;
  // a loaded 0 wraps first, giving the full 2**CNT_W ticks
  function automatic logic at_last(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  logic halt_evt, load_evt, reload_mode;

  assign halt_evt    = cmd.stop || cmd.tmo_set || cmd.tmo_clr;
  assign load_evt    = !halt_evt &&
                       ((cmd.start && !tmo_en) || (tmo_en && rx_char));
  assign reload_mode = (mode == M_TIMER) && !tmo_en;
  assign term_evt    = running && tick_en && at_last(count) &&
                       !halt_evt && !load_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
      ct_out  <= 1'b0;
      ct_flag <= 1'b0;
    end else if (halt_evt) begin
      running <= 1'b0;
      ct_out  <= 1'b0;
      if (cmd.stop) ct_flag <= 1'b0;
    end else if (load_evt) begin
      count   <= preset;
      running <= 1'b1;
      ct_out  <= 1'b0;
    end else if (term_evt) begin
      ct_flag <= 1'b1;
      if (reload_mode) begin
        count  <= preset;
        ct_out <= ~ct_out;
      end else begin
        count   <= '0;
        running <= 1'b0;
        ct_out  <= 1'b1;
      end
    end else if (running && tick_en) begin
      count <= step_down(count);
    end
  end

  // R5: the flag only ever rises right after a terminal count
  a_r5_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ct_flag) |-> $past(term_evt));
  // R5: stop clears flag and output
  a_r5_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.stop |=> (!ct_flag && !ct_out));
  // R5: an idle counter holds its value unless loaded
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load_evt) |=> $stable(count));
  // R3: timer terminal reloads and toggles
  a_r3_timer_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (term_evt && reload_mode) |=>
      (ct_out != $past(ct_out)) && (count == $past(preset)) && running);
  // R4 / R7: one-shot and time-out terminal stop at zero with output high
  a_r4_r7_halt_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (term_evt && !reload_mode) |=> (!running && count == '0 && ct_out));
  // R6: a receiver strobe in time-out mode restarts from the preset
  a_r6_rx_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_en && rx_char && !halt_evt) |=> (running && count == $past(preset)));
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
  import ctmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              rx_char,
  output logic              ct_out,
  output logic              ct_flag
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] count, preset;
  ct_mode_e         mode;
  logic             tmo_en, running, term_evt;
  ct_cmd_t          cmd;

  ctmr_regif #(.BYTE_W(BYTE_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .live_count(count), .preset(preset), .mode(mode), .tmo_en(tmo_en),
    .cmd(cmd)
  );

  ctmr_engine #(.CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rx_char(rx_char),
    .preset(preset), .mode(mode), .tmo_en(tmo_en), .cmd(cmd),
    .count(count), .running(running), .ct_out(ct_out), .ct_flag(ct_flag),
    .term_evt(term_evt)
  );

  // R6: outside time-out mode a receiver strobe alone changes nothing
  a_r6_rx_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmo_en && rx_char && !reg_wr && !tick_en) |=> $stable(count));
endmodule

// File: tb/sim_ctmr_core.sv
`timescale 1ns/1ps
module sim_ctmr_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, rx_char = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ct_out, ct_flag;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ctmr_core u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_char(rx_char), .ct_out(ct_out),
    .ct_flag(ct_flag)
  );

  // {mode, preset, ticks, expected count, expected out, expected flag}
  localparam int NV = 10;
  localparam logic [50:0] VEC [NV] = '{
    {1'b0, 16'd5,      16'd3,  16'd2,      1'b0, 1'b0},
    {1'b0, 16'd5,      16'd5,  16'd5,      1'b1, 1'b1},
    {1'b0, 16'd5,      16'd7,  16'd3,      1'b1, 1'b1},
    {1'b0, 16'd5,      16'd10, 16'd5,      1'b0, 1'b1},
    {1'b0, 16'd1,      16'd3,  16'd1,      1'b1, 1'b1},
    {1'b1, 16'd4,      16'd3,  16'd1,      1'b0, 1'b0},
    {1'b1, 16'd4,      16'd4,  16'd0,      1'b1, 1'b1},
    {1'b1, 16'd4,      16'd9,  16'd0,      1'b1, 1'b1},
    {1'b1, 16'h0102,   16'd2,  16'h0100,   1'b0, 1'b0},
    {1'b1, 16'h0000,   16'd3,  16'hFFFD,   1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic rx_pulse();
    @(negedge clk);
    rx_char = 1'b1;
    @(negedge clk);
    rx_char = 1'b0;
  endtask

  task automatic rd_count(output logic [15:0] v);
    logic [7:0] lo;
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 3'd1;
    #1 lo = reg_rdata;
    @(negedge clk);
    reg_addr = 3'd0;
    #1 v = {reg_rdata, lo};
    reg_rd = 1'b0;
  endtask

  task automatic setup(input logic m, input logic [15:0] p);
    wr(3'd3, 8'h00);
    wr(3'd0, p[15:8]);
    wr(3'd1, p[7:0]);
    wr(3'd4, {7'd0, m});
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    rd_count(v);
    check("R9 count", v, 0);
    check("R9 ct_out", ct_out, 0);
    check("R9 ct_flag", ct_flag, 0);

    // R1 R2 R3 R4: vector table
    for (int i = 0; i < NV; i++) begin
      setup(VEC[i][50], VEC[i][49:34]);
      wr(3'd2, 8'h00);
      ticks(int'(VEC[i][33:18]));
      rd_count(v);
      check($sformatf("R1/R2/R3/R4 vec%0d count", i), v, VEC[i][17:2]);
      check($sformatf("R3/R4 vec%0d ct_out", i), ct_out, VEC[i][1]);
      check($sformatf("R5 vec%0d ct_flag", i), ct_flag, VEC[i][0]);
    end

    // R2: zero preset expires after exactly 65536 ticks
    setup(1'b1, 16'h0000);
    wr(3'd2, 8'h00);
    ticks(65535);
    check("R2 zero preset not yet", ct_flag, 0);
    rd_count(v);
    check("R2 zero preset count", v, 1);
    ticks(1);
    check("R2 zero preset expired", ct_flag, 1);

    // R5: stop clears flag and output, freezes count; start leaves flag
    wr(3'd3, 8'h00);
    check("R5 stop flag", ct_flag, 0);
    check("R5 stop out", ct_out, 0);
    setup(1'b0, 16'd10);
    wr(3'd2, 8'h00);
    ticks(3);
    wr(3'd3, 8'h00);
    ticks(4);
    rd_count(v);
    check("R5 frozen count", v, 7);
    setup(1'b0, 16'd2);
    wr(3'd2, 8'h00);
    ticks(2);
    wr(3'd2, 8'h00);
    check("R5 start keeps flag", ct_flag, 1);

    // R8: upper byte latched on low-byte read
    setup(1'b1, 16'h0101);
    wr(3'd2, 8'h00);
    ticks(1);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 3'd1;
    #1 check("R8 low byte", reg_rdata, 8'h00);
    @(negedge clk);
    reg_rd = 1'b0;
    ticks(1);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 3'd0;
    #1 check("R8 latched high", reg_rdata, 8'h01);
    @(negedge clk);
    reg_rd = 1'b0;
    rd_count(v);
    check("R8 fresh pair", v, 16'h00FF);

    // R6: time-out mode ignores start
    setup(1'b1, 16'd6);
    wr(3'd5, 8'h00);
    rd_count(c0);
    wr(3'd2, 8'h00);
    ticks(3);
    rd_count(v);
    check("R6 start ignored count", v, c0);
    check("R6 start ignored flag", ct_flag, 0);
    // R6: receiver strobe starts and restarts
    rx_pulse();
    ticks(4);
    rd_count(v);
    check("R6 rx start count", v, 2);
    rx_pulse();
    rd_count(v);
    check("R6 rx restart count", v, 6);
    ticks(5);
    check("R6 no early flag", ct_flag, 0);
    // R7: expiry after a pause
    ticks(1);
    check("R7 flag", ct_flag, 1);
    check("R7 out", ct_out, 1);
    ticks(10);
    rd_count(v);
    check("R7 held zero", v, 0);
    // R6: leaving time-out mode
    wr(3'd6, 8'h00);
    check("R6 clear out", ct_out, 0);
    wr(3'd4, 8'h00);
    wr(3'd2, 8'h00);
    ticks(6);
    check("R6 timer after clear out", ct_out, 1);
    ticks(2);
    rx_pulse();
    rd_count(v);
    check("R6 rx ignored outside", v, 4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule